// File: doc/BRIEF.md
# Age-Ordered Dual Issue Selector

This block is the wakeup and selection core of an out-of-order issue queue. It holds renamed instructions in a fixed pool of slots. Each slot keeps two source operand tags with their ready flags, a destination tag, a functional-unit class and a program counter. Four result buses broadcast the physical tags being produced. Any waiting operand whose tag matches a valid broadcast becomes ready.

Each cycle the selector looks at every entry whose two operands are ready and grants up to two of them. Program age decides the winner, not the slot number. The first grant is the oldest ready entry. The second grant is the oldest ready entry that remains. Granted entries leave the queue at the next clock edge. One new instruction per cycle can enter through the dispatch port, into the lowest free slot. A full flag refuses dispatch while every slot is occupied. A flush input empties the whole queue.

Age is held in a pairwise age matrix, which is updated whenever a slot is allocated. A freed low-numbered slot that is refilled therefore holds a younger instruction than the higher-numbered slots around it.

Top module: `iq_dual_select`

## Requirements
- R1: After reset the queue is empty: `full` is 0 and both issue valids are 0.
- R2: When `disp_valid` is high and `full` and `flush` are low, the instruction is stored and can be granted from the next cycle on, provided both of its operands are ready.
- R3: A valid tag on any of the four wakeup ports that equals a waiting source tag of a busy entry makes that operand ready from the next cycle on. A tag that does not match changes nothing.
- R4: A wakeup in the same cycle as a dispatch is also compared with the incoming source tags, so an operand produced in that cycle is not lost.
- R5: Issue port 0 carries the oldest entry, by dispatch order, among those with both operands ready. Issue port 1 carries the next oldest such entry. Slot position has no influence on either choice.
- R6: At most two grants are made per cycle, and they are to different entries. Issue port 1 is never valid without port 0. Each port outputs the destination tag, the program counter and the unit class of its entry. The unit class is encoded as ALU=0, MULT=1, LSU=2, BRANCH=3.
- R7: A granted entry is removed at the next clock edge and is never granted a second time.
- R8: `full` is 1 exactly when all ENTRIES slots are busy. A dispatch offered while `full` is 1 is ignored.
- R9: When `flush` is high, both issue valids are 0 and a dispatch in the same cycle is ignored. From the next cycle on the queue is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Empties the queue at the next edge |
| disp_valid | input | 1 | Dispatch request |
| disp_src_a_tag | input | TAG_W | First source physical tag |
| disp_src_a_rdy | input | 1 | First source already ready |
| disp_src_b_tag | input | TAG_W | Second source physical tag |
| disp_src_b_rdy | input | 1 | Second source already ready |
| disp_dst_tag | input | TAG_W | Destination physical tag |
| disp_fu | input | 2 | Unit class (ALU=0, MULT=1, LSU=2, BRANCH=3) |
| disp_pc | input | PC_W | Program counter |
| wk_valid | input | WK_PORTS | Per-port broadcast valid |
| wk_tag | input | WK_PORTS*TAG_W | Broadcast tags, port p in bits [p*TAG_W +: TAG_W] |
| full | output | 1 | All slots busy |
| iss0_valid | output | 1 | Oldest-ready grant valid |
| iss0_dst | output | TAG_W | Destination tag of grant 0 |
| iss0_fu | output | 2 | Unit class of grant 0 |
| iss0_pc | output | PC_W | Program counter of grant 0 |
| iss1_valid | output | 1 | Second grant valid |
| iss1_dst | output | TAG_W | Destination tag of grant 1 |
| iss1_fu | output | 2 | Unit class of grant 1 |
| iss1_pc | output | PC_W | Program counter of grant 1 |

## Verification
The hardest situation to reach is one where age order and slot order disagree. In that situation a young instruction sits in a low slot while older ready work waits in higher slots. The stimulus creates it by filling the queue, waking entries out of order so that some middle slots drain, and then dispatching a new ready entry into a freed low slot in the same cycle that an older high-slot entry is woken. A long pseudo-random phase follows, with a small tag alphabet, so that wakeups hit often and dispatch, drain, same-cycle wakeup and flush overlap. Every cycle is compared with a bench model that ranks entries by program counter.

// File: rtl/iq_sel_pkg.sv
package iq_sel_pkg;
    typedef enum logic [1:0] {
        FU_ALU    = 2'd0,
        FU_MULT   = 2'd1,
        FU_LSU    = 2'd2,
        FU_BRANCH = 2'd3
    } fu_class_e;
endpackage

// File: rtl/iq_age_matrix.sv
module iq_age_matrix #(
    parameter int N = 32,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 alloc_valid,
    input  logic [IW-1:0]        alloc_idx,
    output logic [N-1:0][N-1:0]  older_q
);
    // older_q[r][c] = 1 : entry in slot r is older than entry in slot c
    logic [N-1:0][N-1:0] older_d;

    always_comb begin
        older_d = older_q;
        if (alloc_valid) begin
            for (int j = 0; j < N; j++) begin
                older_d[alloc_idx][j] = 1'b0;
                older_d[j][alloc_idx] = (IW'(j) != alloc_idx);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) older_q <= '0;
        else        older_q <= older_d;
    end
endmodule

// File: rtl/iq_oldest_pick.sv
module iq_oldest_pick #(
    parameter int N = 32
) (
    input  logic [N-1:0]         req,
    input  logic [N-1:0][N-1:0]  older,
    output logic [N-1:0]         grant
);
    for (genvar i = 0; i < N; i++) begin : g_col
        logic [N-1:0] beaten;
        for (genvar j = 0; j < N; j++) begin : g_row
            assign beaten[j] = (i != j) && req[j] && older[j][i];
        end
        assign grant[i] = req[i] && !(|beaten);
    end

    always_comb begin
        AST_PICK_ONEHOT: assert ($onehot0(grant) || $isunknown(req)); // R6
    end
endmodule

// File: rtl/iq_low_enc.sv
module iq_low_enc #(
    parameter int N = 32,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          hit
);
    always_comb begin
        idx = '0;
        hit = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx = IW'(i);
                hit = 1'b1;
            end
        end
    end
endmodule

// File: rtl/iq_dual_select.sv
module iq_dual_select
    import iq_sel_pkg::*;
#(
    parameter int ENTRIES  = 32,
    parameter int TAG_W    = 6,
    parameter int WK_PORTS = 4,
    parameter int PC_W     = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      flush,
    input  logic                      disp_valid,
    input  logic [TAG_W-1:0]          disp_src_a_tag,
    input  logic                      disp_src_a_rdy,
    input  logic [TAG_W-1:0]          disp_src_b_tag,
    input  logic                      disp_src_b_rdy,
    input  logic [TAG_W-1:0]          disp_dst_tag,
    input  logic [1:0]                disp_fu,
    input  logic [PC_W-1:0]           disp_pc,
    input  logic [WK_PORTS-1:0]       wk_valid,
    input  logic [WK_PORTS*TAG_W-1:0] wk_tag,
    output logic                      full,
    output logic                      iss0_valid,
    output logic [TAG_W-1:0]          iss0_dst,
    output logic [1:0]                iss0_fu,
    output logic [PC_W-1:0]           iss0_pc,
    output logic                      iss1_valid,
    output logic [TAG_W-1:0]          iss1_dst,
    output logic [1:0]                iss1_fu,
    output logic [PC_W-1:0]           iss1_pc
);
    localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef struct packed {
        logic             busy;
        logic [TAG_W-1:0] a_tag;
        logic             a_rdy;
        logic [TAG_W-1:0] b_tag;
        logic             b_rdy;
        logic [TAG_W-1:0] dst;
        fu_class_e        fu;
        logic [PC_W-1:0]  pc;
    } slot_t;

    typedef struct packed {
        slot_t [ENTRIES-1:0] ent;
    } iq_state_t;

    iq_state_t st_d, st_q;

    logic [ENTRIES-1:0]              busy_v, req0, req1, gnt0, gnt1;
    logic [ENTRIES-1:0][ENTRIES-1:0] older_q;
    logic [IW-1:0]                   g0_idx, g1_idx, free_idx;
    logic                            g0_hit, g1_hit, free_hit, accept;

    function automatic logic wake_hit(
        input logic [TAG_W-1:0]          t,
        input logic [WK_PORTS-1:0]       v,
        input logic [WK_PORTS*TAG_W-1:0] tags
    );
        logic h;
        h = 1'b0;
        for (int p = 0; p < WK_PORTS; p++) begin
            if (v[p] && (tags[p*TAG_W +: TAG_W] == t)) h = 1'b1;
        end
        return h;
    endfunction

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            busy_v[i] = st_q.ent[i].busy;
            req0[i]   = st_q.ent[i].busy && st_q.ent[i].a_rdy && st_q.ent[i].b_rdy;
        end
    end

    assign req1 = req0 & ~gnt0;

    iq_oldest_pick #(.N(ENTRIES)) u_pick0 (.req(req0), .older(older_q), .grant(gnt0));
    iq_oldest_pick #(.N(ENTRIES)) u_pick1 (.req(req1), .older(older_q), .grant(gnt1));

    iq_low_enc #(.N(ENTRIES)) u_enc_g0   (.vec(gnt0),    .idx(g0_idx),   .hit(g0_hit));
    iq_low_enc #(.N(ENTRIES)) u_enc_g1   (.vec(gnt1),    .idx(g1_idx),   .hit(g1_hit));
    iq_low_enc #(.N(ENTRIES)) u_enc_free (.vec(~busy_v), .idx(free_idx), .hit(free_hit));

    assign full   = !free_hit;
    assign accept = disp_valid && free_hit && !flush;

    iq_age_matrix #(.N(ENTRIES)) u_age (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_valid(accept),
        .alloc_idx  (free_idx),
        .older_q    (older_q)
    );

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < ENTRIES; i++) begin
            if (st_q.ent[i].busy) begin
                if (wake_hit(st_q.ent[i].a_tag, wk_valid, wk_tag)) st_d.ent[i].a_rdy = 1'b1;
                if (wake_hit(st_q.ent[i].b_tag, wk_valid, wk_tag)) st_d.ent[i].b_rdy = 1'b1;
            end
            if (gnt0[i] || gnt1[i]) st_d.ent[i].busy = 1'b0;
            if (accept && (free_idx == IW'(i))) begin
                st_d.ent[i].busy  = 1'b1;
                st_d.ent[i].a_tag = disp_src_a_tag;
                st_d.ent[i].a_rdy = disp_src_a_rdy || wake_hit(disp_src_a_tag, wk_valid, wk_tag);
                st_d.ent[i].b_tag = disp_src_b_tag;
                st_d.ent[i].b_rdy = disp_src_b_rdy || wake_hit(disp_src_b_tag, wk_valid, wk_tag);
                st_d.ent[i].dst   = disp_dst_tag;
                st_d.ent[i].fu    = fu_class_e'(disp_fu);
                st_d.ent[i].pc    = disp_pc;
            end
            if (flush) st_d.ent[i].busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign iss0_valid = g0_hit && !flush;
    assign iss0_dst   = st_q.ent[g0_idx].dst;
    assign iss0_fu    = st_q.ent[g0_idx].fu;
    assign iss0_pc    = st_q.ent[g0_idx].pc;
    assign iss1_valid = g1_hit && !flush;
    assign iss1_dst   = st_q.ent[g1_idx].dst;
    assign iss1_fu    = st_q.ent[g1_idx].fu;
    assign iss1_pc    = st_q.ent[g1_idx].pc;

    AST_ISS1_NEEDS_ISS0: assert property (@(posedge clk) disable iff (!rst_n)
        iss1_valid |-> iss0_valid); // R6
    AST_DISTINCT_GRANTS: assert property (@(posedge clk) disable iff (!rst_n)
        (iss0_valid && iss1_valid) |-> (g0_idx != g1_idx)); // R6
    AST_AGE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (iss0_valid && iss1_valid) |-> older_q[g0_idx][g1_idx]); // R5
    AST_GRANT_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
        iss0_valid |=> !busy_v[$past(g0_idx)]); // R7
    AST_FULL_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !flush) |=> ($countones(busy_v) <= $past($countones(busy_v)))); // R8
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (busy_v == '0)); // R9
endmodule

// File: tb/iq_dual_select_tb.sv
`timescale 1ns/1ps
module iq_dual_select_tb_top;
    localparam int N  = 8;
    localparam int TW = 6;
    localparam int WP = 4;
    localparam int PW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush_r = 1'b0;
    logic disp_valid = 1'b0;
    logic [TW-1:0] a_tag = '0, b_tag = '0, dst_tag = '0;
    logic a_rdy = 1'b0, b_rdy = 1'b0;
    logic [1:0] fu_in = '0;
    logic [PW-1:0] pc_in = '0;
    logic [WP-1:0] wk_valid = '0;
    logic [WP*TW-1:0] wk_tag = '0;
    logic full, iss0_valid, iss1_valid;
    logic [TW-1:0] iss0_dst, iss1_dst;
    logic [1:0] iss0_fu, iss1_fu;
    logic [PW-1:0] iss0_pc, iss1_pc;

    always #2 clk = ~clk;

    iq_dual_select #(.ENTRIES(N), .TAG_W(TW), .WK_PORTS(WP), .PC_W(PW)) dut_i (
        .clk(clk), .rst_n(rst_n), .flush(flush_r),
        .disp_valid(disp_valid), .disp_src_a_tag(a_tag), .disp_src_a_rdy(a_rdy),
        .disp_src_b_tag(b_tag), .disp_src_b_rdy(b_rdy), .disp_dst_tag(dst_tag),
        .disp_fu(fu_in), .disp_pc(pc_in), .wk_valid(wk_valid), .wk_tag(wk_tag),
        .full(full),
        .iss0_valid(iss0_valid), .iss0_dst(iss0_dst), .iss0_fu(iss0_fu), .iss0_pc(iss0_pc),
        .iss1_valid(iss1_valid), .iss1_dst(iss1_dst), .iss1_fu(iss1_fu), .iss1_pc(iss1_pc)
    );

    // bench model: age is the program counter, which rises with every offer
    bit m_busy[N];
    int m_a[N], m_b[N], m_dst[N], m_fu[N];
    bit m_ar[N], m_br[N];
    longint m_pc[N];
    int attempt = 0;
    int total = 0, bad = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    function automatic bit wk_match(input int t);
        for (int p = 0; p < WP; p++)
            if (wk_valid[p] && (wk_tag[p*TW +: TW] == t[TW-1:0])) return 1'b1;
        return 1'b0;
    endfunction

    task automatic put(input int ta, input bit ra, input int tb, input bit rb);
        disp_valid = 1'b1;
        a_tag = ta[TW-1:0]; a_rdy = ra;
        b_tag = tb[TW-1:0]; b_rdy = rb;
        dst_tag = attempt[TW-1:0];
        fu_in = attempt[1:0];
        pc_in = 32'h4000 + 32'(attempt) * 4;
        attempt++;
    endtask

    task automatic wk(input int p, input int t);
        wk_valid[p] = 1'b1;
        wk_tag[p*TW +: TW] = t[TW-1:0];
    endtask

    task automatic cycle(input string tag);
        int e0, e1, cnt;
        bit exp_full;
        #1;
        cnt = 0; e0 = -1; e1 = -1;
        for (int i = 0; i < N; i++) if (m_busy[i]) cnt++;
        for (int i = 0; i < N; i++)
            if (m_busy[i] && m_ar[i] && m_br[i] && (e0 < 0 || m_pc[i] < m_pc[e0])) e0 = i;
        for (int i = 0; i < N; i++)
            if (i != e0 && m_busy[i] && m_ar[i] && m_br[i] && (e1 < 0 || m_pc[i] < m_pc[e1])) e1 = i;
        if (flush_r) begin e0 = -1; e1 = -1; end
        exp_full = (cnt == N);
        chk(full == exp_full, tag, "full", full, exp_full);
        chk(iss0_valid == (e0 >= 0), tag, "iss0_valid", iss0_valid, e0 >= 0);
        chk(iss1_valid == (e1 >= 0), tag, "iss1_valid", iss1_valid, e1 >= 0);
        if (e0 >= 0 && iss0_valid) begin
            chk(iss0_pc == m_pc[e0], tag, "iss0_pc", iss0_pc, m_pc[e0]);
            chk(iss0_dst == m_dst[e0][TW-1:0], tag, "iss0_dst", iss0_dst, m_dst[e0]);
            chk(iss0_fu == m_fu[e0][1:0], tag, "iss0_fu R6", iss0_fu, m_fu[e0]);
        end
        if (e1 >= 0 && iss1_valid) begin
            chk(iss1_pc == m_pc[e1], tag, "iss1_pc", iss1_pc, m_pc[e1]);
            chk(iss1_dst == m_dst[e1][TW-1:0], tag, "iss1_dst", iss1_dst, m_dst[e1]);
            chk(iss1_fu == m_fu[e1][1:0], tag, "iss1_fu R6", iss1_fu, m_fu[e1]);
        end
        if (flush_r) begin
            for (int i = 0; i < N; i++) m_busy[i] = 1'b0;
        end else begin
            for (int i = 0; i < N; i++) if (m_busy[i]) begin
                if (wk_match(m_a[i])) m_ar[i] = 1'b1;
                if (wk_match(m_b[i])) m_br[i] = 1'b1;
            end
            if (e0 >= 0) m_busy[e0] = 1'b0;
            if (e1 >= 0) m_busy[e1] = 1'b0;
            if (disp_valid && cnt < N) begin
                int s;
                s = -1;
                for (int i = N - 1; i >= 0; i--) if (!m_busy[i]) s = i;
                m_busy[s] = 1'b1;
                m_a[s] = int'(a_tag); m_ar[s] = a_rdy || wk_match(int'(a_tag));
                m_b[s] = int'(b_tag); m_br[s] = b_rdy || wk_match(int'(b_tag));
                m_dst[s] = int'(dst_tag); m_fu[s] = int'(fu_in); m_pc[s] = longint'(pc_in);
            end
        end
        @(negedge clk);
        disp_valid = 1'b0; wk_valid = '0; flush_r = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) m_busy[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: empty after reset
        cycle("R1"); cycle("R1");
        // R2: a ready entry is granted the cycle after dispatch
        put(1, 1, 2, 1); cycle("R2"); cycle("R2"); cycle("R2");
        // R3: operands woken through two different ports
        put(5, 0, 9, 0); cycle("R3"); wk(1, 7); cycle("R3");
        wk(2, 5); cycle("R3"); cycle("R3");
        wk(3, 9); cycle("R3"); cycle("R3"); cycle("R3");
        // R4: wakeup in the dispatch cycle
        put(12, 0, 13, 0); wk(0, 12); wk(1, 13); cycle("R4"); cycle("R4"); cycle("R4");
        // R8: fill every slot, then offer one more
        for (int k = 0; k < N; k++) begin put(16 + k, 0, 40, 1); cycle("R8"); end
        put(1, 1, 1, 1); cycle("R8"); cycle("R8");
        // R5: wake four at once, out of order
        wk(0, 23); wk(1, 22); wk(2, 17); wk(3, 19); cycle("R5");
        cycle("R5"); cycle("R5");
        // R5: young entry lands in a freed low slot while an older high slot wakes
        put(2, 1, 2, 1); wk(0, 21); cycle("R5"); cycle("R5"); cycle("R5");
        // R7: drain the rest, nothing issues twice
        wk(0, 16); wk(1, 18); wk(2, 20); cycle("R7");
        repeat (4) cycle("R7");
        // R9: flush with a dispatch in the same cycle
        put(3, 1, 3, 1); cycle("R9");
        put(4, 0, 4, 1); cycle("R9");
        put(3, 1, 3, 1); flush_r = 1'b1; cycle("R9");
        repeat (3) cycle("R9");
        // mixed traffic with a small tag alphabet
        for (int c = 0; c < 4000; c++) begin
            if ($urandom % 3 != 0) put($urandom % 8, ($urandom % 4) == 0, $urandom % 8, ($urandom % 4) == 0);
            for (int p = 0; p < WP; p++) if ($urandom % 2 == 0) wk(p, $urandom % 8);
            if ($urandom % 250 == 0) flush_r = 1'b1;
            cycle("R5");
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule